// File: doc/BRIEF.md
# Two-Channel Serial Audio Port Data Interrupt Generator

This block sits between the CPU-facing data registers of a two-channel serial audio port and its interrupt controller. For each channel and each direction it holds outgoing or incoming words in a small queue. The queue is a single holding register when queueing is off and a FIFO of `DEPTH` words when it is on. The block also keeps the status the CPU polls: transmit-empty, receive-ready, and the sticky underrun and overrun exception flags.

From that status it raises two registered interrupt requests per channel and direction. The "exception" request fires while the corresponding error flag is set. The "clean" request fires while that flag is clear. Software can therefore route error handling to its own vector.

On the transmit side the trigger is an empty queue, gated by the transmit interrupt enable and the transmitter enable. On the receive side the trigger is a word waiting in the holding register, or a completely full FIFO, gated by the receive interrupt enable. Channel 1 takes part only when the two-channel mode select is high. Otherwise it is idle, and its interrupts stay low.

Top module: `asp_irq_gen`

## Requirements
- R1: After a synchronous reset both transmit queues are empty (`tx_empty` = 2'b11), both receive queues are empty (`rx_ready` = 2'b00), all exception flags are clear and all eight interrupt outputs are low.
- R2: A queue holds one word when `fifo_en` is 0 and `DEPTH` words when it is 1. A CPU write or serial push into a full queue stores nothing.
- R3: A CPU write (`cpu_tx_wr`, `cpu_tx_ch` = channel index) to an active channel whose transmit queue is not full clears that channel's `tx_empty` at the next edge. `tx_empty` follows the queue occupancy whatever the value of `tx_en`.
- R4: A serial pull (`ser_tx_pull[n]`) acts only while `tx_en` is 1. It presents the oldest stored word on `ser_tx_data[n*W +: W]` after the edge. A pull from an empty queue sets that channel's underrun flag instead.
- R5: A CPU read (`cpu_rx_rd`, `cpu_rx_ch`) of a non-empty active receive queue presents its oldest word on `cpu_rx_data` after the edge and removes it. `rx_ready[n]` is 1 when the queue holds a word (`fifo_en` = 0), or holds exactly `DEPTH` words (`fifo_en` = 1). It drops once a read takes the occupancy below that.
- R6: A serial push (`ser_rx_push[n]`, accepted only while `rx_en` is 1) into a full receive queue sets that channel's overrun flag and drops the word. Underrun and overrun flags stay set until a 1 is written to the matching bit of `exc_clr_tx` / `exc_clr_rx`. A set in the same cycle as a clear wins.
- R7: `tx_irq_exc[n]` is high one cycle after a cycle in which `tx_ie`, `tx_en`, channel activity, the empty condition and the underrun flag were all true. `tx_irq_clean[n]` uses the same condition with the underrun flag false.
- R8: `rx_irq_exc[n]` is high one cycle after a cycle in which `rx_ie`, channel activity, `rx_ready[n]` and the overrun flag were all true. `rx_irq_clean[n]` uses the same condition with the overrun flag false.
- R9: Channel 1 is active only while `dual_mode` is 1. While it is inactive, writes, reads, pulls and pushes on channel 1 have no effect and its four interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; gates serial pulls and transmit interrupts |
| rx_en | input | 1 | Receiver enable; gates serial pushes |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| fifo_en | input | 1 | 1: queues hold DEPTH words; 0: single holding register |
| dual_mode | input | 1 | 1: channel 1 active |
| cpu_tx_wr | input | 1 | CPU transmit data write strobe |
| cpu_tx_ch | input | 1 | Channel of the CPU write |
| cpu_tx_data | input | W | CPU transmit word |
| cpu_rx_rd | input | 1 | CPU receive data read strobe |
| cpu_rx_ch | input | 1 | Channel of the CPU read |
| cpu_rx_data | output | W | Word returned by the last CPU read |
| exc_clr_tx | input | 2 | Write-one-to-clear of the underrun flags, bit n = channel n |
| exc_clr_rx | input | 2 | Write-one-to-clear of the overrun flags, bit n = channel n |
| ser_tx_pull | input | 2 | Serial side takes a word, bit n = channel n |
| ser_tx_data | output | 2*W | Word taken by the last pull, channel n at bits n*W +: W |
| ser_rx_push | input | 2 | Serial side delivers a word, bit n = channel n |
| ser_rx_data | input | 2*W | Delivered words, channel n at bits n*W +: W |
| tx_empty | output | 2 | Transmit queue empty per channel |
| tx_underrun | output | 2 | Sticky underrun flags |
| rx_ready | output | 2 | Receive ready/full per channel |
| rx_overrun | output | 2 | Sticky overrun flags |
| tx_irq_exc | output | 2 | Transmit interrupt, exception variant |
| tx_irq_clean | output | 2 | Transmit interrupt, clean variant |
| rx_irq_exc | output | 2 | Receive interrupt, exception variant |
| rx_irq_clean | output | 2 | Receive interrupt, clean variant |

## Verification
The bench builds the block with `DEPTH` = 4 and `W` = 8. At that depth a handful of cycles fills any queue past its limit and drains it past empty. Every configuration of the two enables, the receive interrupt enable, queueing and two-channel mode can then be swept with overflow, underrun, overrun and the flag clears reached in each one. A long pseudo-random phase then mixes writes, reads, pulls, pushes, clears and configuration changes. This phase reaches same-cycle collisions such as a pull and a write on an empty queue, or a set and a clear of one flag. Every output is compared each cycle against occupancy and flags kept arithmetically in the bench.

// File: rtl/asp_irq_pkg.sv
package asp_irq_pkg;
  localparam int NCH = 2;

  typedef struct packed {
    logic exc;
    logic clean;
  } irq_pair_t;
endpackage

// File: rtl/asp_word_queue.sv
module asp_word_queue #(
  parameter int W     = 16,
  parameter int DEPTH = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lim_one,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty,
  output logic         push_drop,
  output logic         pop_miss
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] level;
  logic          push_ok, pop_ok;

  assign empty     = (level == '0);
  assign full      = lim_one ? !empty : (level == CW'(DEPTH));
  assign push_ok   = push && !full;
  assign pop_ok    = pop && !empty;
  assign push_drop = push && full;
  assign pop_miss  = pop && empty;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
    if (pop_ok)  pop_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      level <= level + CW'(push_ok) - CW'(pop_ok);
    end
  end

  a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));
  a_r2_drop_keeps_level: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(level));
  a_r4_pop_lowers: assert property (@(posedge clk) disable iff (rst)
    (pop && !empty && !push) |=> (level == $past(level) - 1'b1));
endmodule

// File: rtl/asp_exc_irq.sv
module asp_exc_irq
  import asp_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      set,
  input  logic      clr,
  input  logic      cond,
  input  logic      gate,
  output logic      flag,
  output irq_pair_t irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= '0;
    end else begin
      if (set)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      irq.exc   <= gate && cond && flag;
      irq.clean <= gate && cond && !flag;
    end
  end

  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  a_r7_exc_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq.exc |-> $past(flag));
  a_r8_clean_needs_cond: assert property (@(posedge clk) disable iff (rst)
    irq.clean |-> $past(cond && gate && !flag));
endmodule

// File: rtl/asp_irq_gen.sv
module asp_irq_gen
  import asp_irq_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             tx_ie,
  input  logic             rx_ie,
  input  logic             fifo_en,
  input  logic             dual_mode,
  input  logic             cpu_tx_wr,
  input  logic             cpu_tx_ch,
  input  logic [W-1:0]     cpu_tx_data,
  input  logic             cpu_rx_rd,
  input  logic             cpu_rx_ch,
  output logic [W-1:0]     cpu_rx_data,
  input  logic [1:0]       exc_clr_tx,
  input  logic [1:0]       exc_clr_rx,
  input  logic [1:0]       ser_tx_pull,
  output logic [2*W-1:0]   ser_tx_data,
  input  logic [1:0]       ser_rx_push,
  input  logic [2*W-1:0]   ser_rx_data,
  output logic [1:0]       tx_empty,
  output logic [1:0]       tx_underrun,
  output logic [1:0]       rx_ready,
  output logic [1:0]       rx_overrun,
  output logic [1:0]       tx_irq_exc,
  output logic [1:0]       tx_irq_clean,
  output logic [1:0]       rx_irq_exc,
  output logic [1:0]       rx_irq_clean
);
  logic [W-1:0] rx_word [NCH];
  logic         rd_ch_q;

  always_ff @(posedge clk) begin
    if (rst)            rd_ch_q <= 1'b0;
    else if (cpu_rx_rd) rd_ch_q <= cpu_rx_ch;
  end
  assign cpu_rx_data = rx_word[rd_ch_q];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic      active;
    logic      tx_push, tx_pop, tx_full, tx_drop, tx_miss;
    logic      rx_push, rx_pop, rx_empty, rx_drop, rx_miss;
    irq_pair_t tx_irq, rx_irq;

    assign active  = (g == 0) ? 1'b1 : dual_mode;
    assign tx_push = cpu_tx_wr && (cpu_tx_ch == 1'(g)) && active;
    assign tx_pop  = ser_tx_pull[g] && tx_en && active;
    assign rx_push = ser_rx_push[g] && rx_en && active;
    assign rx_pop  = cpu_rx_rd && (cpu_rx_ch == 1'(g)) && active;

    asp_word_queue #(.W(W), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst(rst), .lim_one(!fifo_en),
      .push(tx_push), .push_data(cpu_tx_data),
      .pop(tx_pop), .pop_data(ser_tx_data[g*W +: W]),
      .full(tx_full), .empty(tx_empty[g]),
      .push_drop(tx_drop), .pop_miss(tx_miss)
    );

    asp_word_queue #(.W(W), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst(rst), .lim_one(!fifo_en),
      .push(rx_push), .push_data(ser_rx_data[g*W +: W]),
      .pop(rx_pop), .pop_data(rx_word[g]),
      .full(rx_ready[g]), .empty(rx_empty),
      .push_drop(rx_drop), .pop_miss(rx_miss)
    );

    asp_exc_irq u_txirq (
      .clk(clk), .rst(rst), .set(tx_miss), .clr(exc_clr_tx[g]),
      .cond(tx_empty[g]), .gate(tx_ie && tx_en && active),
      .flag(tx_underrun[g]), .irq(tx_irq)
    );

    asp_exc_irq u_rxirq (
      .clk(clk), .rst(rst), .set(rx_drop), .clr(exc_clr_rx[g]),
      .cond(rx_ready[g]), .gate(rx_ie && active),
      .flag(rx_overrun[g]), .irq(rx_irq)
    );

    assign tx_irq_exc[g]   = tx_irq.exc;
    assign tx_irq_clean[g] = tx_irq.clean;
    assign rx_irq_exc[g]   = rx_irq.exc;
    assign rx_irq_clean[g] = rx_irq.clean;

    a_r3_write_fills: assert property (@(posedge clk) disable iff (rst)
      (tx_push && tx_empty[g]) |=> !tx_empty[g]);
  end

  a_r7_tx_masked: assert property (@(posedge clk) disable iff (rst)
    !(tx_ie && tx_en) |=> (tx_irq_exc == 2'b00 && tx_irq_clean == 2'b00));
  a_r8_rx_masked: assert property (@(posedge clk) disable iff (rst)
    !rx_ie |=> (rx_irq_exc == 2'b00 && rx_irq_clean == 2'b00));
  a_r9_idle_chan: assert property (@(posedge clk) disable iff (rst)
    !dual_mode |=> !(tx_irq_exc[1] || tx_irq_clean[1] || rx_irq_exc[1] || rx_irq_clean[1]));
endmodule

// File: tb/test_asp_irq_gen.sv
module test_asp_irq_gen;
  localparam int W = 8;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 0, rx_en = 0, tx_ie = 0, rx_ie = 0, fifo_en = 0, dual_mode = 0;
  logic cpu_tx_wr = 0, cpu_tx_ch = 0, cpu_rx_rd = 0, cpu_rx_ch = 0;
  logic [W-1:0] cpu_tx_data = '0;
  logic [1:0] exc_clr_tx = 0, exc_clr_rx = 0, ser_tx_pull = 0, ser_rx_push = 0;
  logic [2*W-1:0] ser_rx_data = '0;
  logic [W-1:0] cpu_rx_data;
  logic [2*W-1:0] ser_tx_data;
  logic [1:0] tx_empty, tx_underrun, rx_ready, rx_overrun;
  logic [1:0] tx_irq_exc, tx_irq_clean, rx_irq_exc, rx_irq_clean;

  always #2.5 clk = ~clk;

  asp_irq_gen #(.W(W), .DEPTH(P)) i_asp_irq_gen (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [W-1:0] tm [2][P];
  logic [W-1:0] rm [2][P];
  int tc [2];
  int rc [2];
  bit tu [2];
  bit ro [2];
  logic [W-1:0] dseq = 8'h10;
  logic [31:0] lfsr = 32'hACE1_2468;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    bit nx_te [2], nx_tc [2], nx_re [2], nx_rc [2];
    bit chk_s [2];
    bit chk_r;
    logic [W-1:0] exp_s [2];
    logic [W-1:0] exp_r;
    int cap;
    cap = fifo_en ? P : 1;
    chk_r = 0;
    exp_r = '0;
    cpu_tx_data = dseq;
    ser_rx_data = {dseq + 8'd64, dseq + 8'd128};
    dseq = dseq + 1'b1;
    for (int n = 0; n < 2; n++) begin
      bit act, st, so;
      int pt, pr;
      act = (n == 0) || dual_mode;
      pt = tc[n];
      pr = rc[n];
      nx_te[n] = tx_ie && tx_en && act && (pt == 0) && tu[n];
      nx_tc[n] = tx_ie && tx_en && act && (pt == 0) && !tu[n];
      nx_re[n] = rx_ie && act && (pr >= cap) && ro[n];
      nx_rc[n] = rx_ie && act && (pr >= cap) && !ro[n];
      chk_s[n] = 0;
      exp_s[n] = '0;
      st = 0;
      so = 0;
      if (ser_tx_pull[n] && tx_en && act) begin
        if (pt == 0) st = 1;
        else begin
          exp_s[n] = tm[n][0];
          chk_s[n] = 1;
          for (int k = 0; k < P - 1; k++) tm[n][k] = tm[n][k+1];
          tc[n]--;
        end
      end
      if (cpu_tx_wr && cpu_tx_ch == 1'(n) && act && pt < cap) begin
        tm[n][tc[n]] = cpu_tx_data;
        tc[n]++;
      end
      if (cpu_rx_rd && cpu_rx_ch == 1'(n) && act && pr > 0) begin
        exp_r = rm[n][0];
        chk_r = 1;
        for (int k = 0; k < P - 1; k++) rm[n][k] = rm[n][k+1];
        rc[n]--;
      end
      if (ser_rx_push[n] && rx_en && act) begin
        if (pr >= cap) so = 1;
        else begin
          rm[n][rc[n]] = ser_rx_data[n*W +: W];
          rc[n]++;
        end
      end
      if (st) tu[n] = 1;
      else if (exc_clr_tx[n]) tu[n] = 0;
      if (so) ro[n] = 1;
      else if (exc_clr_rx[n]) ro[n] = 0;
    end
    @(posedge clk);
    @(negedge clk);
    for (int n = 0; n < 2; n++) begin
      chk(tx_empty[n] == (tc[n] == 0), "R3 R9 tx_empty", tx_empty[n], tc[n] == 0);
      chk(rx_ready[n] == (rc[n] >= cap), "R5 R2 rx_ready", rx_ready[n], rc[n] >= cap);
      chk(tx_underrun[n] == tu[n], "R4 R6 underrun", tx_underrun[n], tu[n]);
      chk(rx_overrun[n] == ro[n], "R6 overrun", rx_overrun[n], ro[n]);
      chk(tx_irq_exc[n] == nx_te[n], "R7 R9 tx_irq_exc", tx_irq_exc[n], nx_te[n]);
      chk(tx_irq_clean[n] == nx_tc[n], "R7 R9 tx_irq_clean", tx_irq_clean[n], nx_tc[n]);
      chk(rx_irq_exc[n] == nx_re[n], "R8 R9 rx_irq_exc", rx_irq_exc[n], nx_re[n]);
      chk(rx_irq_clean[n] == nx_rc[n], "R8 R9 rx_irq_clean", rx_irq_clean[n], nx_rc[n]);
      if (chk_s[n])
        chk(ser_tx_data[n*W +: W] == exp_s[n], "R4 R2 ser_tx_data", ser_tx_data[n*W +: W], exp_s[n]);
    end
    if (chk_r) chk(cpu_rx_data == exp_r, "R5 R2 cpu_rx_data", cpu_rx_data, exp_r);
    cpu_tx_wr = 0; cpu_rx_rd = 0; ser_tx_pull = 0; ser_rx_push = 0;
    exc_clr_tx = 0; exc_clr_rx = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 2; n++) begin
      tc[n] = 0; rc[n] = 0; tu[n] = 0; ro[n] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(tx_empty == 2'b11, "R1 tx_empty", tx_empty, 3);
    chk(rx_ready == 2'b00, "R1 rx_ready", rx_ready, 0);
    chk({tx_underrun, rx_overrun} == 4'b0, "R1 flags", {tx_underrun, rx_overrun}, 0);
    chk({tx_irq_exc, tx_irq_clean, rx_irq_exc, rx_irq_clean} == 8'b0, "R1 irqs",
        {tx_irq_exc, tx_irq_clean, rx_irq_exc, rx_irq_clean}, 0);

    // sweep every configuration: overfill, overdrain, clear, drain again
    for (int cfg = 0; cfg < 32; cfg++) begin
      tx_ie = cfg[0]; tx_en = cfg[1]; rx_ie = cfg[2]; fifo_en = cfg[3]; dual_mode = cfg[4];
      rx_en = 1'b1;
      for (int k = 0; k < 2 * (P + 1); k++) begin
        cpu_tx_wr = 1; cpu_tx_ch = k[0];
        ser_rx_push = 2'b11;
        step();
      end
      for (int k = 0; k < 2 * (P + 2); k++) begin
        ser_tx_pull = 2'b11;
        cpu_rx_rd = 1; cpu_rx_ch = k[0];
        step();
      end
      step();
      exc_clr_tx = 2'b11; exc_clr_rx = 2'b11;
      step();
      step();
    end

    // pseudo-random mix including same-cycle collisions and config changes
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cpu_tx_wr = lfsr[0]; cpu_tx_ch = lfsr[1];
      cpu_rx_rd = lfsr[2]; cpu_rx_ch = lfsr[3];
      ser_tx_pull = lfsr[5:4]; ser_rx_push = lfsr[7:6];
      exc_clr_tx = lfsr[9:8] & {2{lfsr[10]}};
      exc_clr_rx = lfsr[12:11] & {2{lfsr[13]}};
      if (i % 64 == 0) begin
        tx_ie = lfsr[14]; tx_en = lfsr[15] | lfsr[24]; rx_en = lfsr[16] | lfsr[25];
        rx_ie = lfsr[17]; fifo_en = lfsr[18]; dual_mode = lfsr[19];
      end
      step();
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule